// File: doc/BRIEF.md
# Not-Recently-Used Page Frame Victim Selector

The block keeps two status bits for each of a fixed set of page frames. A referenced bit records that the frame was touched since the last aging tick. A dirty bit records that the frame was written since it was last loaded. Memory traffic reports reads and writes per frame. A periodic aging tick forgets recent use, and a reload notice marks a frame as freshly filled.

When replacement logic asks for a victim, the block sorts every unlocked frame into one of four classes by its two bits. It picks from the lowest class that has a member. A 16-bit LFSR supplies a start point, so the pick within the class is pseudo-random. The answer comes back one cycle after the request. It carries the frame index and that frame's dirty bit, so write-back can be scheduled elsewhere. If every frame is locked, a none-available pulse is returned in place of a victim.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset, every referenced and dirty bit is 0. victim_vld_o and none_avail_o are 0, and the LFSR holds 16'hACE1.
- R2: An access (ref_vld_i) sets the referenced bit of frame ref_idx_i. When ref_wr_i is also 1, it sets that frame's dirty bit too.
- R3: tick_i clears the referenced bit of every frame and leaves all dirty bits unchanged. An access in the same cycle still sets the referenced bit of its own frame.
- R4: reload_vld_i clears both bits of frame reload_idx_i. An access to the same frame in the same cycle takes precedence, setting its bits as in R2.
- R5: The class code of a frame is {referenced, dirty}: 0 = neither, 1 = dirty only, 2 = referenced only, 3 = both. The victim comes from the lowest class code that holds an unlocked frame.
- R6: A frame whose lock_i bit is 1 is never returned as a victim.
- R7: The start index is the low 4 bits of the LFSR value in the request cycle. Frames are scanned upward from the start index, wrapping from 15 to 0, and the first frame of the winning class is chosen. Each request advances the LFSR once: next = {lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]}. Cycles without a request leave it unchanged.
- R8: The cycle after req_i, victim_vld_o pulses and victim_idx_o carries the chosen frame. victim_dirty_o carries that frame's dirty bit. The choice uses the bits and lock_i as they stood in the request cycle, before that cycle's updates. In a cycle that follows no request, both victim_vld_o and none_avail_o are 0.
- R9: If every frame is locked when a request arrives, none_avail_o pulses in the following cycle and victim_vld_o stays 0. The LFSR still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_vld_i | input | 1 | Frame access event |
| ref_idx_i | input | 4 | Accessed frame |
| ref_wr_i | input | 1 | Access is a write |
| tick_i | input | 1 | Aging tick, clears all referenced bits |
| reload_vld_i | input | 1 | Frame has been reloaded |
| reload_idx_i | input | 4 | Reloaded frame |
| lock_i | input | 16 | Per-frame lock mask |
| req_i | input | 1 | Victim request |
| victim_vld_o | output | 1 | Victim answer valid (one-cycle pulse) |
| victim_idx_o | output | 4 | Victim frame index |
| victim_dirty_o | output | 1 | Dirty bit of the victim |
| none_avail_o | output | 1 | All frames locked at request (pulse) |

## Verification
Any wrong status bit changes a frame's class. It shows up as a wrong victim index or dirty flag on the next request that reaches that frame, one cycle after the request. The bench issues requests often while reads, writes, ticks, reloads and lock patterns are mixed in. A corrupted bit is therefore exposed within a few cycles of the event that caused it. A wrong LFSR step moves the scan start, and the index returned on the following request is then wrong.

// File: rtl/nru_pkg.sv
package nru_pkg;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  typedef enum logic [1:0] {
    CLS_COLD       = 2'd0,
    CLS_DIRTY      = 2'd1,
    CLS_HOT        = 2'd2,
    CLS_HOT_DIRTY  = 2'd3
  } nru_class_e;

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic nru_class_e class_of(input logic r, input logic m);
    return nru_class_e'({r, m});
  endfunction

endpackage

// File: rtl/nru_state.sv
module nru_state #(
  parameter int N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_vld_i,
  input  logic [IDX_W-1:0] ref_idx_i,
  input  logic             ref_wr_i,
  input  logic             tick_i,
  input  logic             reload_vld_i,
  input  logic [IDX_W-1:0] reload_idx_i,
  output logic [N-1:0]     r_o,
  output logic [N-1:0]     m_o
);

  logic [N-1:0] r_q, m_q;

  for (genvar i = 0; i < N; i++) begin : g_frame
    logic hit, rld;
    assign hit = ref_vld_i && (ref_idx_i == IDX_W'(i));
    assign rld = reload_vld_i && (reload_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q[i] <= 1'b0;
        m_q[i] <= 1'b0;
      end else begin
        // access wins over tick and reload
        if (hit)               r_q[i] <= 1'b1;
        else if (rld || tick_i) r_q[i] <= 1'b0;
        if (hit && ref_wr_i)   m_q[i] <= 1'b1;
        else if (rld)          m_q[i] <= 1'b0;
      end
    end
  end

  assign r_o = r_q;
  assign m_o = m_q;

  p_tick_clears_r_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ref_vld_i) |=> (r_q == '0));

  p_dirty_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_vld_i |=> (($past(m_q) & ~m_q) == '0));

  p_write_sets_both_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_vld_i && ref_wr_i) |=> ((r_q & m_q) != '0));

endmodule

// File: rtl/nru_lfsr.sv
module nru_lfsr #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] start_o
);
  import nru_pkg::*;

  logic [15:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    s_q <= LFSR_SEED;
    else if (adv_i) s_q <= lfsr_step(s_q);
  end

  assign start_o = s_q[IDX_W-1:0];

  p_lfsr_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_q != 16'h0);

  p_lfsr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(s_q));

endmodule

// File: rtl/nru_pick.sv
module nru_pick #(
  parameter int N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     r_i,
  input  logic [N-1:0]     m_i,
  input  logic [N-1:0]     lock_i,
  input  logic [IDX_W-1:0] start_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             dirty_o
);
  import nru_pkg::*;

  logic [3:0][N-1:0] cls_mask;
  logic [N-1:0]      win_mask;
  logic [2*N-1:0]    dbl;
  logic [N-1:0]      rot;
  logic [IDX_W-1:0]  off;

  always_comb begin
    cls_mask = '0;
    for (int i = 0; i < N; i++) begin
      cls_mask[class_of(r_i[i], m_i[i])][i] = !lock_i[i];
    end
  end

  // lowest non-empty class wins
  always_comb begin
    win_mask = '0;
    for (int c = 3; c >= 0; c--) begin
      if (|cls_mask[c]) win_mask = cls_mask[c];
    end
  end

  assign dbl = {win_mask, win_mask} >> start_i;
  assign rot = dbl[N-1:0];

  always_comb begin
    off = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) off = IDX_W'(i);
    end
  end

  assign found_o = |win_mask;
  assign idx_o   = start_i + off;
  assign dirty_o = m_i[idx_o];

endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
  parameter int N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_vld_i,
  input  logic [IDX_W-1:0] ref_idx_i,
  input  logic             ref_wr_i,
  input  logic             tick_i,
  input  logic             reload_vld_i,
  input  logic [IDX_W-1:0] reload_idx_i,
  input  logic [N-1:0]     lock_i,
  input  logic             req_i,
  output logic             victim_vld_o,
  output logic [IDX_W-1:0] victim_idx_o,
  output logic             victim_dirty_o,
  output logic             none_avail_o
);
  // N must be a power of two

  logic [N-1:0]     r_bits, m_bits;
  logic [IDX_W-1:0] start, pick_idx;
  logic             pick_found, pick_dirty;

  logic             vld_q, none_q, dirty_q;
  logic [IDX_W-1:0] idx_q;

  nru_state #(.N(N)) i_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_vld_i   (ref_vld_i),
    .ref_idx_i   (ref_idx_i),
    .ref_wr_i    (ref_wr_i),
    .tick_i      (tick_i),
    .reload_vld_i(reload_vld_i),
    .reload_idx_i(reload_idx_i),
    .r_o         (r_bits),
    .m_o         (m_bits)
  );

  nru_lfsr #(.IDX_W(IDX_W)) i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (req_i),
    .start_o(start)
  );

  nru_pick #(.N(N)) i_pick (
    .r_i    (r_bits),
    .m_i    (m_bits),
    .lock_i (lock_i),
    .start_i(start),
    .found_o(pick_found),
    .idx_o  (pick_idx),
    .dirty_o(pick_dirty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      none_q  <= 1'b0;
      dirty_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      vld_q  <= req_i && pick_found;
      none_q <= req_i && !pick_found;
      if (req_i && pick_found) begin
        idx_q   <= pick_idx;
        dirty_q <= pick_dirty;
      end
    end
  end

  assign victim_vld_o   = vld_q;
  assign victim_idx_o   = idx_q;
  assign victim_dirty_o = dirty_q;
  assign none_avail_o   = none_q;

  logic [N-1:0] sel_1h;
  assign sel_1h = N'(1) << idx_q;

  p_resp_needs_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (victim_vld_o || none_avail_o) |-> $past(req_i));

  p_vld_none_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(victim_vld_o && none_avail_o));

  p_victim_unlocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_vld_o |-> (($past(lock_i) & sel_1h) == '0));

  p_none_all_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none_avail_o |-> (&$past(lock_i)));

  p_dirty_matches_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_vld_o |-> (victim_dirty_o == |($past(m_bits) & sel_1h)));

endmodule

// File: tb/test_nru_victim_sel.sv
module test_nru_victim_sel;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_vld = 0, ref_wr = 0, tick = 0, reload_vld = 0, req = 0;
  logic [3:0]  ref_idx = 0, reload_idx = 0;
  logic [15:0] lock_v = 0;
  logic        vld_o, dirty_o, none_o;
  logic [3:0]  idx_o;

  int checks = 0;
  int errors = 0;

  logic        mr [16];
  logic        mm [16];
  logic [15:0] mlfsr;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  nru_victim_sel i_nru_victim_sel (
    .clk_i(clk), .rst_ni(rst_ni),
    .ref_vld_i(ref_vld), .ref_idx_i(ref_idx), .ref_wr_i(ref_wr),
    .tick_i(tick), .reload_vld_i(reload_vld), .reload_idx_i(reload_idx),
    .lock_i(lock_v), .req_i(req),
    .victim_vld_o(vld_o), .victim_idx_o(idx_o),
    .victim_dirty_o(dirty_o), .none_avail_o(none_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:15]);
  endfunction

  task automatic cyc(input logic rv, input logic [3:0] ri, input logic rw,
                     input logic tk, input logic lv, input logic [3:0] li,
                     input logic rq, input string tag);
    int  best, e_idx;
    logic e_found, e_dirty;
    ref_vld = rv; ref_idx = ri; ref_wr = rw; tick = tk;
    reload_vld = lv; reload_idx = li; req = rq;
    best = 4; e_idx = 0; e_found = 0; e_dirty = 0;
    for (int i = 0; i < 16; i++)
      if (!lock_v[i] && (int'({mr[i], mm[i]}) < best)) best = int'({mr[i], mm[i]});
    if (best < 4) begin
      for (int k = 15; k >= 0; k--) begin
        int f;
        f = (int'(mlfsr[3:0]) + k) % 16;
        if (!lock_v[f] && int'({mr[f], mm[f]}) == best) e_idx = f;
      end
      e_found = 1;
      e_dirty = mm[e_idx];
    end
    @(posedge clk);
    for (int i = 0; i < 16; i++) begin
      logic hit, rl;
      hit = rv && (ri == 4'(i));
      rl  = lv && (li == 4'(i));
      if (hit) mr[i] = 1; else if (rl || tk) mr[i] = 0;
      if (hit && rw) mm[i] = 1; else if (rl) mm[i] = 0;
    end
    if (rq) mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
    #1;
    if (rq) begin
      check({tag, " R8 vld"}, int'(vld_o), int'(e_found));
      check({tag, " R9 none"}, int'(none_o), int'(!e_found));
      if (e_found) begin
        check({tag, " R5 R6 R7 idx"}, int'(idx_o), e_idx);
        check({tag, " R8 dirty"}, int'(dirty_o), int'(e_dirty));
      end
    end else begin
      check({tag, " R8 idle"}, int'(vld_o) + int'(none_o), 0);
    end
    @(negedge clk);
    ref_vld = 0; tick = 0; reload_vld = 0; req = 0; ref_wr = 0;
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mr[i] = 0; mm[i] = 0; end
    mlfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    check("R1 vld in reset", int'(vld_o), 0);
    check("R1 none in reset", int'(none_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: first pick starts at seed low nibble (1), all frames class 0
    cyc(0, 0, 0, 0, 0, 0, 1, "R1 first");
    check("R1 R7 seed start", int'(idx_o), 1);

    // R2 R5: read all but frame 5 -> only 5 is class 0
    for (int i = 0; i < 16; i++) if (i != 5) cyc(1, 4'(i), 0, 0, 0, 0, 0, "R2 read");
    cyc(0, 0, 0, 0, 0, 0, 1, "R5 lone cold");
    check("R5 lone cold idx", int'(idx_o), 5);

    // R2: write frame 5 -> class 3, others class 2
    cyc(1, 5, 1, 0, 0, 0, 0, "R2 write");
    cyc(0, 0, 0, 0, 0, 0, 1, "R2 hot pick");

    // R3 R6: tick, lock all but 5 -> dirty-only frame 5
    cyc(0, 0, 0, 1, 0, 0, 0, "R3 tick");
    lock_v = 16'hFFDF;
    cyc(0, 0, 0, 0, 0, 0, 1, "R3 R6 dirty kept");
    check("R3 dirty kept", int'(dirty_o), 1);

    // R9: all locked
    lock_v = 16'hFFFF;
    cyc(0, 0, 0, 0, 0, 0, 1, "R9 all locked");
    check("R9 none pulse", int'(none_o), 1);

    // R4: reload frame 5 clears it; reload with same-cycle write keeps bits
    lock_v = 16'hFFDF;
    cyc(0, 0, 0, 0, 1, 5, 1, "R4 reload req");
    cyc(0, 0, 0, 0, 0, 0, 1, "R4 after reload");
    check("R4 cleared dirty", int'(dirty_o), 0);
    cyc(1, 5, 1, 0, 1, 5, 0, "R4 conflict");
    cyc(0, 0, 0, 0, 0, 0, 1, "R4 access wins");
    check("R4 access wins dirty", int'(dirty_o), 1);
    // R3: tick with same-cycle access keeps that frame referenced
    lock_v = 16'h0000;
    cyc(1, 9, 0, 1, 0, 0, 0, "R3 tick+ref");
    cyc(0, 0, 0, 0, 0, 0, 1, "R3 tick+ref pick");

    // mixed sweep
    for (int n = 0; n < 4000; n++) begin
      int a;
      a = rnd();
      if (n % 150 == 0) lock_v = 16'hFFFF;
      else if (n % 10 == 0) lock_v = 16'(rnd()) & 16'(rnd()) & 16'(rnd());
      cyc(a[0], 4'(rnd()), a[1], (a % 23) == 0, (a % 7) == 0, 4'(rnd()),
          (rnd() % 3) == 0, "R2 R3 R4 R7 sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule